// File: doc/BRIEF.md
# Per-Port Low-Power-Idle Request Controller

This block decides, for each of four LAN ports, when the port's transmit path may enter low-power idle. It watches each port's buffer occupancy, counted in segments. When a port has stayed empty for a programmed number of ticks, the block raises that port's idle request. When data shows up again, the request is dropped after a second programmed number of ticks. If occupancy climbs to the port's wake threshold, the request is dropped at once instead. A shared prescaler makes one tick every 2^TICK_EXP clocks, which is 4096 clocks by default.

Every port has its own wake threshold and its own pair of timeouts. A wake threshold of zero switches the mechanism off for that port. Each port also reports a registered buffer-filled flag, its request level and its running tick counter. The signalling toward the PHY is left to the logic that consumes the request.

Top module: `lpi_req_ctrl`

## Requirements
- R1: During and right after synchronous reset, every request, filled flag and timer output reads 0.
- R2: With a port's wake threshold at 0, its request stays 0 for any occupancy, and its timer reads 0.
- R3: After a port's occupancy goes from nonzero to 0 and then stays 0 with the request low, the request rises a number N of rising edges later. Counting the edge that first samples the zero, N lies between (S-1)*T+3 and S*T+2 when S is 1 or more, and is exactly 2 when S is 0. Here S is the sleep timeout in ticks and T is the tick period in clocks.
- R4: After occupancy goes from 0 to a nonzero value below the wake threshold while the request is high, the request falls within the same window as in R3, with the wake timeout in place of S.
- R5: When occupancy is greater than or equal to a nonzero wake threshold, the request reads 0 after the next rising edge.
- R6: If data arrives while the sleep countdown is running, the countdown is cancelled. The request then stays 0 for as long as the occupancy stays nonzero and below the threshold.
- R7: The filled flag equals (occupancy != 0) as sampled at the previous rising edge.
- R8: The timer output returns to 0 on the edge after any change between empty and non-empty. While the port waits to assert the request, the timer never exceeds the sleep timeout.
- R9: Each port acts only on its own inputs. Activity on one port leaves the requests of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_i | input | NUM_PORTS*OCC_W | Buffer occupancy per port in segments; port p uses bits [p*OCC_W +: OCC_W] |
| wake_thr_i | input | NUM_PORTS*OCC_W | Per-port wake threshold; 0 disables the port |
| sleep_to_i | input | NUM_PORTS*TMR_W | Per-port ticks of emptiness before the request rises |
| wake_to_i | input | NUM_PORTS*TMR_W | Per-port ticks after data arrives before the request falls |
| lpi_req_o | output | NUM_PORTS | Registered idle request per port |
| buf_filled_o | output | NUM_PORTS | Registered flag showing a nonzero buffer per port |
| timer_o | output | NUM_PORTS*TMR_W | Running tick counter per port |

## Verification
The assertions assume that thresholds and timeouts are held steady while a port is counting. They also assume that occupancy is a plain level which may change at any edge. The stimulus changes a port's timeouts only while that port is non-empty with its request low, which is a state in which the counter is not running. It drives occupancy only at falling edges, so each change lands on exactly one rising edge. The tick period is shortened to 8 clocks, and every pair of sleep and wake timeouts from 0 to 3 is swept on each port in turn, with the other ports held awake.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  // Default exponent of the tick period: one tick per 4096 clocks.
  localparam int unsigned TICK_EXP_DEF = 12;

  // Side of the idle boundary a port currently sits on.
  typedef enum logic {
    SIDE_AWAKE  = 1'b0,
    SIDE_ASLEEP = 1'b1
  } lpi_side_e;
endpackage

// File: rtl/lpi_tick_gen.sv
module lpi_tick_gen #(
  parameter int unsigned TICK_EXP = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam logic [TICK_EXP-1:0] LAST = {TICK_EXP{1'b1}};

  logic [TICK_EXP-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= (cnt_q == LAST);
    end
  end

  // Ticks never land on back-to-back cycles (R3 tick spacing).
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lpi_port_ctl.sv
module lpi_port_ctl
  import lpi_pkg::*;
#(
  parameter int unsigned OCC_W = 16,
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] thx_i,
  input  logic [TMR_W-1:0] ton_i,
  input  logic [TMR_W-1:0] tof_i,
  output logic             req_o,
  output logic             filled_o,
  output logic [TMR_W-1:0] timer_o
);
  lpi_side_e side_q;
  logic      empty_now;
  logic      edge_seen;
  logic      waiting;
  logic [TMR_W-1:0] limit;

  assign empty_now = (occ_i == '0);
  // filled_o still holds last cycle's view; mismatch means a transition.
  assign edge_seen = (filled_o == empty_now);
  // Counting happens only when the buffer state disagrees with the side.
  assign waiting   = empty_now ? (side_q == SIDE_AWAKE) : (side_q == SIDE_ASLEEP);
  assign limit     = empty_now ? ton_i : tof_i;
  assign req_o     = (side_q == SIDE_ASLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q   <= SIDE_AWAKE;
      filled_o <= 1'b0;
      timer_o  <= '0;
    end else begin
      filled_o <= !empty_now;
      if (thx_i == '0) begin
        side_q  <= SIDE_AWAKE;
        timer_o <= '0;
      end else if (occ_i >= thx_i) begin
        side_q  <= SIDE_AWAKE;
        timer_o <= '0;
      end else if (edge_seen) begin
        timer_o <= '0;
      end else if (waiting) begin
        if (timer_o >= limit) begin
          side_q  <= (side_q == SIDE_AWAKE) ? SIDE_ASLEEP : SIDE_AWAKE;
          timer_o <= '0;
        end else if (tick_i) begin
          timer_o <= timer_o + 1'b1;
        end
      end
    end
  end

  // R2: a zero threshold keeps the request low.
  p_disabled_low_r2: assert property (@(posedge clk) disable iff (rst)
    (thx_i == '0) |=> !req_o);

  // R5: occupancy at or above the threshold forces the request low.
  p_force_wake_r5: assert property (@(posedge clk) disable iff (rst)
    ((thx_i != '0) && (occ_i >= thx_i)) |=> !req_o);

  // R3: the request only rises from an empty buffer.
  p_rise_when_empty_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> ($past(occ_i) == '0));

  // R4: the request only falls with data present or the port disabled.
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> (($past(occ_i) != '0) || ($past(thx_i) == '0)));

  // R8: an empty/non-empty change restarts the timer.
  p_timer_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (filled_o != (occ_i != '0)) |=> (timer_o == '0));
endmodule

// File: rtl/lpi_req_ctrl.sv
module lpi_req_ctrl
  import lpi_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned OCC_W     = 16,
  parameter int unsigned TMR_W     = 8,
  parameter int unsigned TICK_EXP  = TICK_EXP_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*OCC_W-1:0] occ_i,
  input  logic [NUM_PORTS*OCC_W-1:0] wake_thr_i,
  input  logic [NUM_PORTS*TMR_W-1:0] sleep_to_i,
  input  logic [NUM_PORTS*TMR_W-1:0] wake_to_i,
  output logic [NUM_PORTS-1:0]       lpi_req_o,
  output logic [NUM_PORTS-1:0]       buf_filled_o,
  output logic [NUM_PORTS*TMR_W-1:0] timer_o
);
  logic tick;

  lpi_tick_gen #(.TICK_EXP(TICK_EXP)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lpi_port_ctl #(.OCC_W(OCC_W), .TMR_W(TMR_W)) port_i (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick),
      .occ_i    (occ_i[p*OCC_W +: OCC_W]),
      .thx_i    (wake_thr_i[p*OCC_W +: OCC_W]),
      .ton_i    (sleep_to_i[p*TMR_W +: TMR_W]),
      .tof_i    (wake_to_i[p*TMR_W +: TMR_W]),
      .req_o    (lpi_req_o[p]),
      .filled_o (buf_filled_o[p]),
      .timer_o  (timer_o[p*TMR_W +: TMR_W])
    );
  end
endmodule

// File: tb/lpi_req_ctrl_tb_top.sv
module lpi_req_ctrl_tb_top;
  localparam int NP = 4;
  localparam int OW = 8;
  localparam int TW = 4;
  localparam int TE = 3;
  localparam int T  = 8;
  localparam int THR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP*OW-1:0] occ = '0;
  logic [NP*OW-1:0] thr = '0;
  logic [NP*TW-1:0] sto = '0;
  logic [NP*TW-1:0] wto = '0;
  logic [NP-1:0]    req;
  logic [NP-1:0]    filled;
  logic [NP*TW-1:0] tmr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lpi_req_ctrl #(.NUM_PORTS(NP), .OCC_W(OW), .TMR_W(TW), .TICK_EXP(TE)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .occ_i        (occ),
    .wake_thr_i   (thr),
    .sleep_to_i   (sto),
    .wake_to_i    (wto),
    .lpi_req_o    (req),
    .buf_filled_o (filled),
    .timer_o      (tmr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lo_win(input int to);
    return (to == 0) ? 2 : (to - 1) * T + 3;
  endfunction

  function automatic int hi_win(input int to);
    return to * T + 2;
  endfunction

  // Counts rising edges until the port's request reaches lvl; tracks max timer.
  task automatic wait_req(input int p, input bit lvl, output int lat, output int maxt);
    lat = 0;
    maxt = 0;
    while (req[p] != lvl && lat < 200) begin
      @(negedge clk);
      lat++;
      if (int'(tmr[p*TW +: TW]) > maxt) maxt = int'(tmr[p*TW +: TW]);
    end
  endtask

  task automatic run_combo(input int p, input int ton, input int tof);
    int lat, maxt, highs;
    occ[p*OW +: OW] = 8'd1;
    sto[p*TW +: TW] = TW'(ton);
    wto[p*TW +: TW] = TW'(tof);
    repeat (2) @(negedge clk);
    // Sleep entry
    occ[p*OW +: OW] = 8'd0;
    wait_req(p, 1'b1, lat, maxt);
    chk(lat >= lo_win(ton) && lat <= hi_win(ton), $sformatf("R3 p%0d ton%0d latency", p, ton), lat, hi_win(ton));
    chk(maxt <= ton, $sformatf("R8 p%0d timer bound", p), maxt, ton);
    chk(filled[p] == 1'b0, "R7 filled after empty", filled[p], 0);
    // Wake by timeout, occupancy just under threshold
    occ[p*OW +: OW] = 8'(THR - 1);
    wait_req(p, 1'b0, lat, maxt);
    chk(lat >= lo_win(tof) && lat <= hi_win(tof), $sformatf("R4 p%0d tof%0d latency", p, tof), lat, hi_win(tof));
    chk(filled[p] == 1'b1, "R7 filled after data", filled[p], 1);
    // Forced wake at the threshold
    occ[p*OW +: OW] = 8'd0;
    wait_req(p, 1'b1, lat, maxt);
    occ[p*OW +: OW] = 8'(THR);
    @(negedge clk);
    chk(req[p] == 1'b0, $sformatf("R5 p%0d forced wake", p), req[p], 0);
    // Cancelled sleep
    if (ton >= 1) begin
      occ[p*OW +: OW] = 8'd0;
      @(negedge clk);
      occ[p*OW +: OW] = 8'd1;
      @(negedge clk);
      chk(tmr[p*TW +: TW] == '0, $sformatf("R8 p%0d timer restart", p), int'(tmr[p*TW +: TW]), 0);
      highs = 0;
      repeat ((ton + 2) * T + 4) begin
        @(negedge clk);
        if (req[p]) highs++;
      end
      chk(highs == 0, $sformatf("R6 p%0d cancelled sleep", p), highs, 0);
    end
    for (int q = 0; q < NP; q++)
      if (q != p) chk(req[q] == 1'b0, $sformatf("R9 port %0d untouched by %0d", q, p), req[q], 0);
  endtask

  initial begin
    int highs;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req == '0, "R1 request after reset", req, 0);
    chk(filled == '0, "R1 filled after reset", filled, 0);
    chk(tmr == '0, "R1 timer after reset", tmr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req == '0 && tmr == '0, "R1 first cycle", req, 0);
    // Disabled ports: empty, then busy, long enough to cover any timeout
    highs = 0;
    sto = '0;
    wto = '0;
    repeat (40) begin
      @(negedge clk);
      if (req != '0 || tmr != '0) highs++;
    end
    occ = {NP{8'd9}};
    repeat (40) begin
      @(negedge clk);
      if (req != '0 || tmr != '0) highs++;
    end
    chk(highs == 0, "R2 disabled ports stay low", highs, 0);
    chk(filled == '1, "R7 filled with data", filled, 15);
    // Enable all ports, awake with data below threshold
    occ = {NP{8'd1}};
    thr = {NP{8'(THR)}};
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          run_combo(p, a, b);
    // Disable one port while it is asleep
    occ[0 +: OW] = 8'd0;
    sto[0 +: TW] = '0;
    repeat (4) @(negedge clk);
    thr[0 +: OW] = '0;
    @(negedge clk);
    chk(req[0] == 1'b0, "R2 disable drops request", req[0], 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule